// File: doc/BRIEF.md
# Card Information Structure Tuple Walker

This block follows a chain of tuples stored in a byte-addressable space and pulls out the function-extension fields (function 0 block size and maximum transfer speed) and the manufacturer fields (manufacturer code and card identifier). On a start pulse it reads a three-byte pointer from a base address that the caller supplies. It then reads each tuple's code and link bytes, fetches the bodies of the tuples it recognises, and jumps over all other data by using the link. Fetches go through a simple request/valid byte port, so the block can sit in front of any bus adapter.

The walk finishes normally when it meets an end marker, which is either a code byte of 0xFF or a link byte of 0xFF. The walk aborts with an error when the chain is longer than a parameterized tuple count, or when the next tuple would lie outside the 17-bit address space. Every extracted field has its own found flag, so software can tell a missing field apart from a field whose value is zero.

Top module: `cis_walker`

## Requirements
- R1: The start pointer is read from three bytes at ptr_base_i, ptr_base_i+1 and ptr_base_i+2, least significant byte first. Only the low 17 bits are used, so bits 7:1 of the third byte are ignored.
- R2: The block raises rd_req_o and holds rd_addr_o. Both stay unchanged until a cycle in which rd_valid_i is high, and the byte on rd_data_i is taken in that cycle.
- R3: A tuple has its code at offset 0, its link at offset 1 and a body of link bytes from offset 2. The next tuple starts at address + 2 + link. A link of 0 means an empty body.
- R4: A code of 0xFF or a link of 0xFF ends the walk. done_o then goes high with error_o low. Both flags stay set, with rd_req_o low, until the next start_i.
- R5: For a tuple with code 0x22 whose body byte at offset 2 is 0x00, the block size is {offset 4, offset 3} and is found only when link >= 3. The speed is offset 5 and is found only when link >= 4. Any other type byte yields nothing.
- R6: For a tuple with code 0x20, the 16-bit manufacturer code is {offset 3, offset 2} and is found when link >= 2. The card identifier is {offset 5, offset 4} and is found when link >= 4.
- R7: Body bytes past offset 5, and the bodies of tuples with other codes, are not interpreted. The walk moves on by the link.
- R8: If a non-end tuple code is met after MAX_TUPLES tuples have been visited, the walk stops with error_o high and done_o low.
- R9: If a tuple's link byte, or the next tuple address, would lie above 0x1FFFF, the walk stops with error_o high.
- R10: After reset, and on every start_i, all found flags, done_o and error_o are low.
- R11: While done_o is high and start_i is low, every extracted field and found flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a walk (taken when idle) |
| ptr_base_i | input | 17 | Address of the three pointer bytes |
| rd_req_o | output | 1 | Byte read request |
| rd_addr_o | output | 17 | Byte read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 8 | Read data byte |
| blk_size_o | output | 16 | Function 0 block size |
| blk_size_found_o | output | 1 | Block size was extracted |
| max_speed_o | output | 8 | Maximum transfer speed byte |
| max_speed_found_o | output | 1 | Speed was extracted |
| manf_id_o | output | 16 | Manufacturer code |
| manf_id_found_o | output | 1 | Manufacturer code was extracted |
| card_id_o | output | 16 | Card identifier |
| card_id_found_o | output | 1 | Card identifier was extracted |
| done_o | output | 1 | Walk ended at an end marker |
| error_o | output | 1 | Walk aborted on limit or range |

## Verification
The assertions check four things on every cycle: that a pending request and its address hold until data arrives, that done and error never appear together and keep the read port quiet, that the extracted fields stay frozen after completion, and that a new start clears the status and the found flags. The scenarios are the only way to show that field positions, the link-length guards, the type-byte check, skipping of long and unknown tuples, pointer truncation, both end markers, the tuple limit and the address-range abort give the right values. Each of these depends on the contents of the chain.

// File: rtl/cis_pkg.sv
package cis_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PTR, ST_CODE, ST_LINK, ST_BODY, ST_COMMIT
  } walk_st_e;

  localparam logic [7:0] CODE_FUNCE = 8'h22;
  localparam logic [7:0] CODE_MANF  = 8'h20;
  localparam logic [7:0] MARK_END   = 8'hFF;
  localparam int unsigned BODY_BYTES = 4;
endpackage

// File: rtl/cis_next_addr.sv
module cis_next_addr #(
  parameter int unsigned ADDR_W = 17
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [7:0]        link_i,
  output logic [ADDR_W-1:0] link_addr_o,
  output logic              link_ovf_o,
  output logic [ADDR_W-1:0] next_o,
  output logic              next_ovf_o
);
  localparam int unsigned SUM_W = ADDR_W + 1;

  logic [SUM_W-1:0] link_sum, next_sum;

  assign link_sum    = {1'b0, base_i} + SUM_W'(1);
  assign next_sum    = {1'b0, base_i} + SUM_W'(2) + {{(SUM_W-8){1'b0}}, link_i};
  assign link_addr_o = link_sum[ADDR_W-1:0];
  assign link_ovf_o  = link_sum[ADDR_W];
  assign next_o      = next_sum[ADDR_W-1:0];
  assign next_ovf_o  = next_sum[ADDR_W];
endmodule

// File: rtl/cis_field_cap.sv
module cis_field_cap
  import cis_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic        commit_i,
  input  logic [7:0]  code_i,
  input  logic [7:0]  link_i,
  input  logic [31:0] body_i,
  output logic [15:0] blk_size_o,
  output logic        blk_size_found_o,
  output logic [7:0]  max_speed_o,
  output logic        max_speed_found_o,
  output logic [15:0] manf_id_o,
  output logic        manf_id_found_o,
  output logic [15:0] card_id_o,
  output logic        card_id_found_o
);
  logic funce_ok, manf_hit;

  assign funce_ok = commit_i && code_i == CODE_FUNCE && link_i != 8'd0 && body_i[7:0] == 8'h00;
  assign manf_hit = commit_i && code_i == CODE_MANF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_size_o <= '0; blk_size_found_o <= 1'b0;
      max_speed_o <= '0; max_speed_found_o <= 1'b0;
      manf_id_o <= '0; manf_id_found_o <= 1'b0;
      card_id_o <= '0; card_id_found_o <= 1'b0;
    end else if (clear_i) begin
      blk_size_o <= '0; blk_size_found_o <= 1'b0;
      max_speed_o <= '0; max_speed_found_o <= 1'b0;
      manf_id_o <= '0; manf_id_found_o <= 1'b0;
      card_id_o <= '0; card_id_found_o <= 1'b0;
    end else begin
      if (funce_ok && link_i >= 8'd3) begin
        blk_size_o       <= body_i[23:8];
        blk_size_found_o <= 1'b1;
      end
      if (funce_ok && link_i >= 8'd4) begin
        max_speed_o       <= body_i[31:24];
        max_speed_found_o <= 1'b1;
      end
      if (manf_hit && link_i >= 8'd2) begin
        manf_id_o       <= body_i[15:0];
        manf_id_found_o <= 1'b1;
      end
      if (manf_hit && link_i >= 8'd4) begin
        card_id_o       <= body_i[31:16];
        card_id_found_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cis_walker.sv
module cis_walker
  import cis_pkg::*;
#(
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned MAX_TUPLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] ptr_base_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [7:0]        rd_data_i,
  output logic [15:0]       blk_size_o,
  output logic              blk_size_found_o,
  output logic [7:0]        max_speed_o,
  output logic              max_speed_found_o,
  output logic [15:0]       manf_id_o,
  output logic              manf_id_found_o,
  output logic [15:0]       card_id_o,
  output logic              card_id_found_o,
  output logic              done_o,
  output logic              error_o
);
  localparam int unsigned CNT_W = $clog2(MAX_TUPLES + 1);
  localparam int unsigned IDX_W = $clog2(BODY_BYTES);

  walk_st_e            st_q;
  logic                req_q, done_q, err_q;
  logic [ADDR_W-1:0]   addr_q, cur_q;
  logic [1:0]          pidx_q;
  logic [7:0]          ptr_lo_q, ptr_mid_q;
  logic [7:0]          code_q, link_q;
  logic [IDX_W-1:0]    bidx_q;
  logic [BODY_BYTES-1:0][7:0] body_q;
  logic [CNT_W-1:0]    cnt_q;

  logic                ack, known, clear, commit;
  logic [23:0]         ptr_full;
  logic                unused_ptr_hi;
  logic [7:0]          nx_link;
  logic [ADDR_W-1:0]   link_addr, next_addr;
  logic                link_ovf, next_ovf;
  logic [IDX_W-1:0]    blast;

  assign ack           = req_q && rd_valid_i;
  assign ptr_full      = {rd_data_i, ptr_mid_q, ptr_lo_q};
  assign unused_ptr_hi = ^ptr_full[23:ADDR_W];
  assign known         = code_q == CODE_FUNCE || code_q == CODE_MANF;
  assign nx_link       = (st_q == ST_LINK) ? rd_data_i : link_q;
  assign blast         = (link_q >= 8'(BODY_BYTES)) ? IDX_W'(BODY_BYTES - 1)
                                                    : link_q[IDX_W-1:0] - IDX_W'(1);
  assign clear         = st_q == ST_IDLE && start_i;
  assign commit        = st_q == ST_COMMIT;

  cis_next_addr #(.ADDR_W(ADDR_W)) i_next (
    .base_i(cur_q), .link_i(nx_link),
    .link_addr_o(link_addr), .link_ovf_o(link_ovf),
    .next_o(next_addr), .next_ovf_o(next_ovf)
  );

  cis_field_cap i_cap (
    .clk_i, .rst_ni, .clear_i(clear), .commit_i(commit),
    .code_i(code_q), .link_i(link_q), .body_i(body_q),
    .blk_size_o, .blk_size_found_o, .max_speed_o, .max_speed_found_o,
    .manf_id_o, .manf_id_found_o, .card_id_o, .card_id_found_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; req_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      addr_q <= '0; cur_q <= '0; pidx_q <= '0; ptr_lo_q <= '0; ptr_mid_q <= '0;
      code_q <= '0; link_q <= '0; bidx_q <= '0; body_q <= '0; cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q <= ST_PTR; pidx_q <= '0; addr_q <= ptr_base_i; req_q <= 1'b1;
          done_q <= 1'b0; err_q <= 1'b0; cnt_q <= '0;
        end
        ST_PTR: if (ack) begin
          if (pidx_q == 2'd2) begin
            cur_q <= ptr_full[ADDR_W-1:0]; addr_q <= ptr_full[ADDR_W-1:0];
            st_q  <= ST_CODE;
          end else begin
            if (pidx_q == 2'd0) ptr_lo_q <= rd_data_i;
            else                ptr_mid_q <= rd_data_i;
            pidx_q <= pidx_q + 2'd1; addr_q <= addr_q + ADDR_W'(1);
          end
        end
        ST_CODE: if (ack) begin
          if (rd_data_i == MARK_END) begin
            done_q <= 1'b1; req_q <= 1'b0; st_q <= ST_IDLE;
          end else if (cnt_q == CNT_W'(MAX_TUPLES) || link_ovf) begin
            err_q <= 1'b1; req_q <= 1'b0; st_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1); code_q <= rd_data_i;
            addr_q <= link_addr; st_q <= ST_LINK;
          end
        end
        ST_LINK: if (ack) begin
          link_q <= rd_data_i;
          if (rd_data_i == MARK_END) begin
            done_q <= 1'b1; req_q <= 1'b0; st_q <= ST_IDLE;
          end else if (next_ovf) begin
            err_q <= 1'b1; req_q <= 1'b0; st_q <= ST_IDLE;
          end else if (known && rd_data_i != 8'd0) begin
            addr_q <= addr_q + ADDR_W'(1); bidx_q <= '0; st_q <= ST_BODY;
          end else begin
            cur_q <= next_addr; addr_q <= next_addr; st_q <= ST_CODE;
          end
        end
        ST_BODY: if (ack) begin
          body_q[bidx_q] <= rd_data_i;
          if (bidx_q == blast) begin
            req_q <= 1'b0; st_q <= ST_COMMIT;
          end else begin
            bidx_q <= bidx_q + IDX_W'(1); addr_q <= addr_q + ADDR_W'(1);
          end
        end
        ST_COMMIT: begin
          cur_q <= next_addr; addr_q <= next_addr; req_q <= 1'b1; st_q <= ST_CODE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o  = req_q;
  assign rd_addr_o = addr_q;
  assign done_o    = done_q;
  assign error_o   = err_q;
endmodule

// File: rtl/cis_walker_chk.sv
module cis_walker_chk #(
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_valid_i,
  input logic [15:0]       blk_size_o,
  input logic              blk_size_found_o,
  input logic [7:0]        max_speed_o,
  input logic              max_speed_found_o,
  input logic [15:0]       manf_id_o,
  input logic              manf_id_found_o,
  input logic [15:0]       card_id_o,
  input logic              card_id_found_o,
  input logic              done_o,
  input logic              error_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o)); // R2

  AST_END_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o)); // R4

  AST_END_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || error_o) |-> !rd_req_o); // R4

  AST_FIELDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> $stable(blk_size_o) && $stable(max_speed_o) &&
      $stable(manf_id_o) && $stable(card_id_o) &&
      $stable({blk_size_found_o, max_speed_found_o, manf_id_found_o, card_id_found_o})); // R11

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (done_o || error_o) |=> !done_o && !error_o &&
      !blk_size_found_o && !max_speed_found_o && !manf_id_found_o && !card_id_found_o); // R10
endmodule

bind cis_walker cis_walker_chk #(.ADDR_W(ADDR_W)) i_cis_walker_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
  .blk_size_o(blk_size_o), .blk_size_found_o(blk_size_found_o),
  .max_speed_o(max_speed_o), .max_speed_found_o(max_speed_found_o),
  .manf_id_o(manf_id_o), .manf_id_found_o(manf_id_found_o),
  .card_id_o(card_id_o), .card_id_found_o(card_id_found_o),
  .done_o(done_o), .error_o(error_o)
);

// File: tb/test_cis_walker.sv
module test_cis_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [16:0] ptr_base = '0;
  logic        rd_req;
  logic [16:0] rd_addr;
  logic        rd_valid = 1'b0;
  logic [7:0]  rd_data = '0;
  logic [15:0] blk_size, manf_id, card_id;
  logic [7:0]  max_speed;
  logic        blk_f, spd_f, mid_f, cid_f, done, err;

  int checks = 0, fails = 0, lat = 1, wait_cnt = 0, hs_viol = 0;
  logic [7:0] mem [4096];

  always #5 clk = ~clk;

  cis_walker i_cis_walker (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ptr_base_i(ptr_base),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .blk_size_o(blk_size), .blk_size_found_o(blk_f), .max_speed_o(max_speed),
    .max_speed_found_o(spd_f), .manf_id_o(manf_id), .manf_id_found_o(mid_f),
    .card_id_o(card_id), .card_id_found_o(cid_f), .done_o(done), .error_o(err)
  );

  // byte memory with configurable latency, aliased on the low 12 address bits
  always @(posedge clk) begin
    if (rd_valid) begin
      rd_valid <= 1'b0; wait_cnt <= 0;
    end else if (rd_req) begin
      if (wait_cnt >= lat - 1) begin
        rd_valid <= 1'b1; rd_data <= mem[rd_addr[11:0]]; wait_cnt <= 0;
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  // R2 handshake monitor
  logic        p_req = 1'b0, p_valid = 1'b0;
  logic [16:0] p_addr = '0;
  always @(negedge clk) begin
    if (rst_n && p_req && !p_valid && (!rd_req || rd_addr != p_addr)) hs_viol++;
    p_req = rd_req; p_valid = rd_valid; p_addr = rd_addr;
  end

  typedef struct packed {
    logic [7:0]  code;
    logic [7:0]  link;
    logic [31:0] body;
    logic        bf;
    logic [15:0] blk;
    logic        sf;
    logic [7:0]  spd;
    logic        mf;
    logic [15:0] mid;
    logic        cf;
    logic [15:0] cid;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h22, 8'h04, 32'h32020000, 1'b1, 16'h0200, 1'b1, 8'h32, 1'b0, 16'h0, 1'b0, 16'h0},
    '{8'h22, 8'h2A, 32'h5A004000, 1'b1, 16'h0040, 1'b1, 8'h5A, 1'b0, 16'h0, 1'b0, 16'h0},
    '{8'h22, 8'h04, 32'h32020001, 1'b0, 16'h0,    1'b0, 8'h00, 1'b0, 16'h0, 1'b0, 16'h0},
    '{8'h22, 8'h03, 32'h00080000, 1'b1, 16'h0800, 1'b0, 8'h00, 1'b0, 16'h0, 1'b0, 16'h0},
    '{8'h20, 8'h04, 32'h12340089, 1'b0, 16'h0,    1'b0, 8'h00, 1'b1, 16'h0089, 1'b1, 16'h1234},
    '{8'h20, 8'h02, 32'h00000296, 1'b0, 16'h0,    1'b0, 8'h00, 1'b1, 16'h0296, 1'b0, 16'h0},
    '{8'h80, 8'h05, 32'h12340089, 1'b0, 16'h0,    1'b0, 8'h00, 1'b0, 16'h0, 1'b0, 16'h0},
    '{8'h22, 8'h00, 32'h00000000, 1'b0, 16'h0,    1'b0, 8'h00, 1'b0, 16'h0, 1'b0, 16'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mem_clear();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
  endtask

  task automatic run(input logic [16:0] base);
    bit ended = 1'b0;
    @(negedge clk); ptr_base = base; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (done || err) begin ended = 1'b1; break; end
      @(negedge clk);
    end
    if (!ended) begin
      checks++; fails++;
      $display("FAIL R4 walk timeout actual=running expected=ended");
    end
  endtask

  initial begin
    #1500000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    mem_clear();
    repeat (3) @(negedge clk);
    // reset state (R10)
    chk("R10 reset done", done, 0);
    chk("R10 reset error", err, 0);
    chk("R10 reset req", rd_req, 0);
    chk("R10 reset found", {blk_f, spd_f, mid_f, cid_f}, 0);
    rst_n = 1'b1;

    // table walk: filler tuple, target tuple, end marker
    for (int v = 0; v < 8; v++) begin
      mem_clear();
      lat = (v % 2) + 1;
      mem[0] = 8'h10; mem[1] = 8'h00; mem[2] = 8'hFE;        // R1 high bits ignored
      mem[16'h10] = 8'h21; mem[16'h11] = 8'h02; mem[16'h12] = 8'h0C; mem[16'h13] = 8'h00;
      mem[16'h14] = VECS[v].code; mem[16'h15] = VECS[v].link;
      for (int k = 0; k < int'(VECS[v].link); k++)
        mem[16'h16 + k] = (k < 4) ? VECS[v].body[8*k +: 8] : 8'hEE;
      mem[16'h16 + VECS[v].link] = 8'hFF;
      run(17'h0);
      chk($sformatf("R1 R3 R7 vec%0d done", v), {done, err}, 2'b10);
      chk($sformatf("R5 vec%0d blk found", v), blk_f, VECS[v].bf);
      if (VECS[v].bf) chk($sformatf("R5 vec%0d blk", v), blk_size, VECS[v].blk);
      chk($sformatf("R5 vec%0d spd found", v), spd_f, VECS[v].sf);
      if (VECS[v].sf) chk($sformatf("R5 vec%0d spd", v), max_speed, VECS[v].spd);
      chk($sformatf("R6 vec%0d mid found", v), mid_f, VECS[v].mf);
      if (VECS[v].mf) chk($sformatf("R6 vec%0d mid", v), manf_id, VECS[v].mid);
      chk($sformatf("R6 vec%0d cid found", v), cid_f, VECS[v].cf);
      if (VECS[v].cf) chk($sformatf("R6 vec%0d cid", v), card_id, VECS[v].cid);
      if (v == 0) begin
        repeat (5) @(negedge clk);
        chk("R11 hold blk", {blk_f, blk_size}, {1'b1, 16'h0200});
        chk("R4 sticky done no req", {done, rd_req}, 2'b10);
      end
    end

    // immediate end code; start also clears stale fields (R4, R10)
    lat = 2;
    mem_clear();
    mem[16'h100] = 8'h00; mem[16'h101] = 8'h02; mem[16'h102] = 8'h00;
    mem[16'h200] = 8'hFF;
    run(17'h100);
    chk("R4 code end", {done, err}, 2'b10);
    chk("R10 fields cleared on start", {blk_f, spd_f, mid_f, cid_f}, 0);

    // end by link byte on a known code
    mem[16'h200] = 8'h22; mem[16'h201] = 8'hFF; mem[16'h202] = 8'h00;
    run(17'h100);
    chk("R4 link end", {done, err}, 2'b10);
    chk("R4 link end nothing found", blk_f, 0);

    // tuple limit: exactly MAX_TUPLES then end, then one more
    mem_clear();
    mem[16'h0] = 8'h00; mem[16'h1] = 8'h03; mem[16'h2] = 8'h00;
    for (int i = 0; i < 16; i++) begin mem[16'h300 + 2*i] = 8'h21; mem[16'h301 + 2*i] = 8'h00; end
    mem[16'h320] = 8'hFF;
    run(17'h0);
    chk("R8 limit exact", {done, err}, 2'b10);
    mem[16'h320] = 8'h21; mem[16'h321] = 8'h00; mem[16'h322] = 8'hFF;
    run(17'h0);
    chk("R8 limit exceeded", {done, err}, 2'b01);

    // address range (R9): tuple at 0x1FFF0 with link 0xF0
    mem[16'h400] = 8'hF0; mem[16'h401] = 8'hFF; mem[16'h402] = 8'h01;
    mem[12'hFF0] = 8'h21; mem[12'hFF1] = 8'hF0;
    run(17'h400);
    chk("R9 range error", {done, err}, 2'b01);
    chk("R9 no request after error", rd_req, 0);

    chk("R2 handshake violations", hs_viol, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule